// File: doc/BRIEF.md
# NAND Page Sector De-interleaver

A raw NAND page reaches this block as a stream of bytes. In that stream each sector's data is followed by the sector's spare area. The spare area holds a few free-data bytes and then the ECC parity bytes. The block writes every accepted byte into an internal page buffer at a computed position. When the page has been received, it reads the buffer out in order as a second byte stream.

In formatted mode the parity bytes are never stored. The output holds the data of every sector back to back, followed by the free-data bytes of each sector in ascending sector order. In raw mode every byte keeps its position, so the page comes out exactly as it went in. For formatted pages an optional bad-block-mark relocation can be enabled. It moves the byte that sits at the conventional mark position inside the last sector's data so that it appears right after the contiguous data, and moves the last sector's first free-data byte into the position that byte has left.

Both streams use valid/ready handshakes. The page geometry and mode bits are captured with the first accepted byte of a page and are held until the last output byte has left. This lets the configuration source prepare the next page while the current one is being processed.

Top module: `pdi_sector_deinterleave`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid`, `page_done`, `ecc_on` and `length_error` are all 0.
- R2: In formatted mode (`cfg_raw`=0), output byte k for k < N·S is input byte (k div S)·(S+P) + (k mod S). Output byte N·S + j is input byte (j div F)·(S+P) + S + (j mod F). Here N = `cfg_nsect_m1`+1, S = sector bytes, F = free-data bytes (at least 1), and P = spare bytes (at least F).
- R3: A formatted page produces exactly N·(S+F) output bytes, so no parity byte appears. `out_last` is high on the final byte only.
- R4: In raw mode (`cfg_raw`=1), the page produces N·(S+P) output bytes equal to the input bytes in arrival order. `out_last` marks the final byte.
- R5: From the first accepted byte of a page until the first byte of the next page, `ecc_on` equals `cfg_ecc_req` AND NOT `cfg_raw` as sampled with that first byte. An ECC request is therefore ignored in raw mode.
- R6: When `cfg_bbm_swap`=1 in formatted mode, with A = N·S − (N−1)·P and B = N·S + (N−1)·F, three output positions change. Output N·S carries the byte R2 assigns to A, output A carries the byte R2 assigns to B, and output B carries the byte R2 assigns to N·S. This requires S ≥ P. In raw mode the swap bit has no effect.
- R7: All configuration inputs are sampled with the first accepted byte of a page. Changes to them after that point do not affect the page.
- R8: `in_ready` is 0 while the buffered page is draining, and input offered during that time is ignored. `page_done` is high exactly in the cycle the final output byte is accepted. One cycle later `in_ready` is 1 and `out_valid` is 0.
- R9: When a page ends (input byte with `in_last`) with a byte count different from N·(S+P), `length_error` goes to 1. It stays at 1 until the first byte of the next page is accepted. Surplus bytes are discarded.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sector_bytes | input | SEC_W | Data bytes per sector (S) |
| cfg_fdm_bytes | input | FDM_W | Free-data bytes per sector (F) |
| cfg_spare_bytes | input | SPR_W | Spare bytes per sector, free data plus parity (P) |
| cfg_nsect_m1 | input | NS_W | Sector count minus one |
| cfg_raw | input | 1 | 1 = raw pass-through, 0 = formatted |
| cfg_ecc_req | input | 1 | ECC requested for the page |
| cfg_bbm_swap | input | 1 | Enable bad-block-mark relocation |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | DW | Input byte |
| in_last | input | 1 | Final byte of the input page |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | DW | Output byte |
| out_last | output | 1 | Final output byte of the page |
| page_done | output | 1 | Final output byte accepted this cycle |
| ecc_on | output | 1 | Effective ECC enable of the current page |
| length_error | output | 1 | Sticky page-length mismatch flag |

## Verification
The bench sweeps sector counts of 1, 2, 3 and 16 across two sector sizes, two free-data sizes and two spare sizes, in all four combinations of raw mode and mark relocation. It compares every output byte against positions derived arithmetically.

An address mapper that slipped by one sector, or that leaked parity bytes, would show wrong bytes or a wrong byte count. A relocation with the wrong rotation would misplace one of three specific bytes. A relocation that was not gated by raw mode would corrupt pass-through pages.

Random back-pressure on both streams, together with junk input offered during draining, exposes a pointer that advances on a stall or a block that accepts input too early. Short, long and mid-page-reconfigured pages catch a length flag that fails to set or to clear, and a configuration that is not held for the whole page.

// File: rtl/pdi_pkg.sv
// Shared limits, configuration record, state encoding and geometry helpers
// for the sector de-interleaver. All sizes of the block derive from here.
package pdi_pkg;
    parameter int SEC_MAX   = 64;   // largest sector data size in bytes
    parameter int FDM_MAX   = 8;    // largest free-data size per sector
    parameter int SPARE_MAX = 16;   // largest spare size per sector
    parameter int NSECT_MAX = 16;   // largest sector count per page

    localparam int SEC_W     = $clog2(SEC_MAX + 1);
    localparam int FDM_W     = $clog2(FDM_MAX + 1);
    localparam int SPR_W     = $clog2(SPARE_MAX + 1);
    localparam int NS_W      = $clog2(NSECT_MAX);
    localparam int BUF_DEPTH = NSECT_MAX * (SEC_MAX + SPARE_MAX);
    localparam int ADDR_W    = $clog2(BUF_DEPTH + 1);
    localparam int CNT_W     = ADDR_W + 1;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_DRAIN} pdi_state_t;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [FDM_W-1:0] fdm;
        logic [SPR_W-1:0] spare;
        logic [NS_W-1:0]  nsect_m1;
        logic             raw;
        logic             ecc;
        logic             swap;
    } pdi_cfg_t;

    function automatic addr_t nsect(input pdi_cfg_t c);
        return addr_t'(c.nsect_m1) + addr_t'(1);
    endfunction

    function automatic addr_t raw_bytes(input pdi_cfg_t c);
        return nsect(c) * (addr_t'(c.sec) + addr_t'(c.spare));
    endfunction

    function automatic addr_t fmt_bytes(input pdi_cfg_t c);
        return nsect(c) * (addr_t'(c.sec) + addr_t'(c.fdm));
    endfunction
endpackage

// File: rtl/pdi_addr_map.sv
// Write-side address mapper. Given the position of an input byte inside its
// sector region and the running bases, it returns the buffer address and
// whether the byte is stored. Assumes F >= 1 and S >= P when swap is used.
module pdi_addr_map
    import pdi_pkg::*;
(
    input  logic [SEC_W-1:0] sec,
    input  logic [FDM_W-1:0] fdm,
    input  logic [SPR_W-1:0] spare,
    input  logic [NS_W-1:0]  nsect_m1,
    input  logic             raw,
    input  logic             swap,
    input  addr_t            pos,
    input  addr_t            data_base,
    input  addr_t            fdm_base,
    input  logic [CNT_W-1:0] in_cnt,
    output logic             keep,
    output addr_t            wr_addr,
    output addr_t            exp_len
);
    addr_t sec_a, fdm_a, n_a, page, mark_src, mark_alt, lin;
    logic  in_page, is_data, is_fdm;

    // Compute the page geometry, the linear target and the relocation.
    always_comb begin
        sec_a    = addr_t'(sec);
        fdm_a    = addr_t'(fdm);
        n_a      = addr_t'(nsect_m1) + addr_t'(1);
        page     = n_a * sec_a;
        exp_len  = n_a * (sec_a + addr_t'(spare));
        mark_src = page - addr_t'(nsect_m1) * addr_t'(spare);
        mark_alt = page + addr_t'(nsect_m1) * fdm_a;
        in_page  = in_cnt < CNT_W'(exp_len);
        is_data  = pos < sec_a;
        is_fdm   = !is_data && (pos < sec_a + fdm_a);
        lin      = is_data ? (data_base + pos) : (page + fdm_base + (pos - sec_a));
        if (raw) begin
            keep    = in_page;
            wr_addr = in_cnt[ADDR_W-1:0];
        end else begin
            keep    = in_page && (is_data || is_fdm);
            wr_addr = lin;
            if (swap) begin
                if (lin == mark_src)      wr_addr = page;
                else if (lin == mark_alt) wr_addr = mark_src;
                else if (lin == page)     wr_addr = mark_alt;
            end
        end
    end
endmodule

// File: rtl/pdi_page_ram.sv
// Page buffer: one synchronous write port, one combinational read port.
// Assumes the reader never addresses a location in the cycle it is written.
module pdi_page_ram #(
    parameter int DEPTH = 1280,
    parameter int AW    = 11,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store the incoming byte at its mapped location.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pdi_drain.sv
// Read pointer for the drain phase. It walks the buffer from 0 to len-1,
// advancing only on an accepted byte. Assumes len >= 1 while active.
module pdi_drain #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          out_ready,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] rd_ptr,
    output logic          last,
    output logic          done
);
    assign last = active && (rd_ptr == len - AW'(1));
    assign done = last && out_ready;

    // Advance on each accepted byte; rewind after the final one.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rd_ptr <= '0;
        else if (active && out_ready) rd_ptr <= last ? '0 : rd_ptr + AW'(1);
    end

    // R10: a stalled byte keeps its position
    assert_stall_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        active && !out_ready |=> active && $stable(rd_ptr));

    // R3: the pointer never runs past the page length
    assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> rd_ptr < len);
endmodule

// File: rtl/pdi_sector_deinterleave.sv
// Top of the sector de-interleaver. It captures the configuration with the
// first byte of a page, fills the page buffer through the address mapper,
// and then drains the buffer in order. Assumes F >= 1 and P >= F.
module pdi_sector_deinterleave
    import pdi_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] cfg_sector_bytes,
    input  logic [FDM_W-1:0] cfg_fdm_bytes,
    input  logic [SPR_W-1:0] cfg_spare_bytes,
    input  logic [NS_W-1:0]  cfg_nsect_m1,
    input  logic             cfg_raw,
    input  logic             cfg_ecc_req,
    input  logic             cfg_bbm_swap,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DW-1:0]    in_data,
    input  logic             in_last,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [DW-1:0]    out_data,
    output logic             out_last,
    output logic             page_done,
    output logic             ecc_on,
    output logic             length_error
);
    pdi_state_t       state;
    pdi_cfg_t         cfg_live, cfg_q, cfg_eff;
    logic             in_acc, wr_keep;
    logic [CNT_W-1:0] in_cnt;
    addr_t            pos, data_base, fdm_base, wr_addr, exp_len, out_len, rd_ptr, reg_last;

    assign cfg_live = '{sec: cfg_sector_bytes, fdm: cfg_fdm_bytes, spare: cfg_spare_bytes,
                        nsect_m1: cfg_nsect_m1, raw: cfg_raw, ecc: cfg_ecc_req,
                        swap: cfg_bbm_swap};
    assign cfg_eff   = (state == ST_IDLE) ? cfg_live : cfg_q;
    assign in_ready  = (state != ST_DRAIN);
    assign in_acc    = in_valid && in_ready;
    assign out_valid = (state == ST_DRAIN);
    assign out_len   = cfg_q.raw ? raw_bytes(cfg_q) : fmt_bytes(cfg_q);
    assign reg_last  = addr_t'(cfg_eff.sec) + addr_t'(cfg_eff.spare) - addr_t'(1);
    assign ecc_on    = cfg_q.ecc && !cfg_q.raw;

    pdi_addr_map u_map (
        .sec(cfg_eff.sec), .fdm(cfg_eff.fdm), .spare(cfg_eff.spare),
        .nsect_m1(cfg_eff.nsect_m1), .raw(cfg_eff.raw), .swap(cfg_eff.swap),
        .pos(pos), .data_base(data_base), .fdm_base(fdm_base), .in_cnt(in_cnt),
        .keep(wr_keep), .wr_addr(wr_addr), .exp_len(exp_len)
    );

    pdi_page_ram #(.DEPTH(BUF_DEPTH), .AW(ADDR_W), .DW(DW)) u_ram (
        .clk(clk), .we(in_acc && wr_keep), .waddr(wr_addr), .wdata(in_data),
        .raddr(rd_ptr), .rdata(out_data)
    );

    pdi_drain #(.AW(ADDR_W)) u_drain (
        .clk(clk), .rst_n(rst_n), .active(out_valid), .out_ready(out_ready),
        .len(out_len), .rd_ptr(rd_ptr), .last(out_last), .done(page_done)
    );

    // Page sequencing and configuration capture on the first byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cfg_q <= '0;
        end else begin
            case (state)
                ST_IDLE:  if (in_valid) begin
                              cfg_q <= cfg_live;
                              state <= in_last ? ST_DRAIN : ST_FILL;
                          end
                ST_FILL:  if (in_valid && in_last) state <= ST_DRAIN;
                ST_DRAIN: if (page_done) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Input position tracking: total count, offset in region, running bases.
    always_ff @(posedge clk) begin
        if (!rst_n || (in_acc && in_last)) begin
            in_cnt    <= '0;
            pos       <= '0;
            data_base <= '0;
            fdm_base  <= '0;
        end else if (in_acc) begin
            if (in_cnt != '1) in_cnt <= in_cnt + CNT_W'(1);
            if (pos == reg_last) begin
                pos       <= '0;
                data_base <= data_base + addr_t'(cfg_eff.sec);
                fdm_base  <= fdm_base + addr_t'(cfg_eff.fdm);
            end else begin
                pos <= pos + addr_t'(1);
            end
        end
    end

    // Sticky length flag: judged at the page end, cleared by the next page.
    always_ff @(posedge clk) begin
        if (!rst_n)                         length_error <= 1'b0;
        else if (in_acc && in_last)         length_error <= (in_cnt + CNT_W'(1)) != CNT_W'(exp_len);
        else if (in_acc && state == ST_IDLE) length_error <= 1'b0;
    end

    // R2: formatted writes land inside the formatted page
    assert_fmt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_acc && wr_keep && !cfg_eff.raw |-> wr_addr < fmt_bytes(cfg_eff));

    // R8: after the final output byte the block is accepting again
    assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |=> in_ready && !out_valid);

    // R10: a stalled output byte holds
    assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R9: the flag only rises at the end of an input page
    assert_err_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(length_error) |-> $past(in_acc && in_last));

    // R5: the effective ECC enable only changes at a page start
    assert_ecc_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ecc_on) |-> $past(state == ST_IDLE && in_valid));
endmodule

// File: tb/sim_pdi_sector_deinterleave.sv
// Sweep bench: drives pages over a small geometry grid with random gaps and
// back-pressure, and checks every output byte against arithmetic positions.
module sim_pdi_sector_deinterleave;
    timeunit 1ns;
    timeprecision 100ps;
    import pdi_pkg::*;

    logic             clk, rst_n;
    logic [SEC_W-1:0] cfg_sector_bytes;
    logic [FDM_W-1:0] cfg_fdm_bytes;
    logic [SPR_W-1:0] cfg_spare_bytes;
    logic [NS_W-1:0]  cfg_nsect_m1;
    logic             cfg_raw, cfg_ecc_req, cfg_bbm_swap;
    logic             in_valid, in_ready, in_last;
    logic [7:0]       in_data, out_data;
    logic             out_valid, out_ready, out_last, page_done, ecc_on, length_error;

    int         errs = 0;
    int         checks = 0;
    int         seed = 0;
    int         rng = 1;
    logic [7:0] exp_b [2048];

    pdi_sector_deinterleave u0 (.*);

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int s);
        return 8'((i * 13 + s * 29 + 5) & 255);
    endfunction

    task automatic run_page(input int S, input int F, input int SP, input int n,
                            input bit raw, input bit ecc, input bit swp,
                            input int delta, input bit scr, input bit chkd);
        int    exp_in, send_len, olen, page, a_src, b_alt, got;
        logic [7:0] t;
        string dtag;
        seed++;
        exp_in   = n * (S + SP);
        send_len = exp_in + delta;
        page     = n * S;
        olen     = raw ? exp_in : n * (S + F);
        for (int k = 0; k < olen; k++) begin
            int r;
            if (raw)          r = k;
            else if (k < page) r = (k / S) * (S + SP) + (k % S);
            else              r = ((k - page) / F) * (S + SP) + S + ((k - page) % F);
            exp_b[k] = pat(r, seed);
        end
        if (!raw && swp) begin
            a_src = page - (n - 1) * SP;
            b_alt = page + (n - 1) * F;
            t = exp_b[page];
            exp_b[page]  = exp_b[a_src];
            exp_b[a_src] = exp_b[b_alt];
            exp_b[b_alt] = t;
        end
        if (scr)          dtag = "R7 data under mid-page config change";
        else if (raw && swp) dtag = "R6 swap ignored in raw, R4 data";
        else if (raw)     dtag = "R4 raw data";
        else if (swp)     dtag = "R6 relocated data";
        else              dtag = "R2 formatted data";
        @(negedge clk);
        cfg_sector_bytes = SEC_W'(S);
        cfg_fdm_bytes    = FDM_W'(F);
        cfg_spare_bytes  = SPR_W'(SP);
        cfg_nsect_m1     = NS_W'(n - 1);
        cfg_raw = raw; cfg_ecc_req = ecc; cfg_bbm_swap = swp;
        got = 0;
        fork
            begin : sender
                int i = 0;
                bit once = 0;
                while (i < send_len) begin
                    @(negedge clk);
                    if (i == 1 && !once) begin
                        once = 1;
                        chk(length_error == 1'b0, "R9 flag cleared at page start", int'(length_error), 0);
                        if (scr) begin
                            cfg_sector_bytes = SEC_W'(S + 4);
                            cfg_fdm_bytes    = FDM_W'(F + 1);
                            cfg_spare_bytes  = SPR_W'(SP + 2);
                            cfg_nsect_m1     = NS_W'(n == 1 ? 2 : 0);
                            cfg_raw = ~raw; cfg_ecc_req = ~ecc; cfg_bbm_swap = ~swp;
                        end
                    end
                    rng = rng * 1103515245 + 12345;
                    if (rng[20:18] == 3'd0) begin
                        in_valid = 1'b0;
                        in_last  = 1'b0;
                    end else begin
                        in_valid = 1'b1;
                        in_data  = pat(i, seed);
                        in_last  = (i == send_len - 1);
                        if (in_ready) i++;
                    end
                end
                @(negedge clk);
                in_valid = 1'b1; in_data = 8'hA5; in_last = 1'b0;
            end
            begin : receiver
                int k = 0;
                bit fin = 0;
                bit stalled = 0;
                logic [7:0] held;
                while (!fin) begin
                    @(negedge clk);
                    rng = rng * 1103515245 + 12345;
                    out_ready = (rng[17:16] != 2'd0);
                    #0.1;
                    if (stalled) begin
                        chk(out_valid && out_data == held, "R10 stalled byte holds", int'(out_data), int'(held));
                        stalled = 0;
                    end
                    if (out_valid) begin
                        if (k == 0) chk(!in_ready, "R8 input blocked while draining", int'(in_ready), 0);
                        if (out_ready) begin
                            if (chkd) chk(out_data == exp_b[k], dtag, int'(out_data), int'(exp_b[k]));
                            chk(out_last == (k == olen - 1), raw ? "R4 last flag" : "R3 last flag",
                                int'(out_last), int'(k == olen - 1));
                            chk(page_done == out_last, "R8 page_done with final byte", int'(page_done), int'(out_last));
                            if (out_last) begin
                                fin = 1;
                                in_valid = 1'b0;
                            end
                            k++;
                        end else begin
                            stalled = 1;
                            held = out_data;
                        end
                    end
                end
                got = k;
            end
        join
        @(negedge clk);
        out_ready = 1'b0;
        chk(got == olen, raw ? "R4 raw byte count" : "R3 formatted byte count", got, olen);
        chk(length_error == (delta != 0), "R9 length flag", int'(length_error), int'(delta != 0));
        chk(ecc_on == (ecc && !raw), "R5 effective ECC", int'(ecc_on), int'(ecc && !raw));
        chk(in_ready && !out_valid, "R8 accepting after drain", int'(in_ready), 1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        int ns [4] = '{1, 2, 3, 16};
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0; out_ready = 1'b0;
        cfg_sector_bytes = '0; cfg_fdm_bytes = '0; cfg_spare_bytes = '0; cfg_nsect_m1 = '0;
        cfg_raw = 1'b0; cfg_ecc_req = 1'b0; cfg_bbm_swap = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        chk(page_done == 1'b0, "R1 reset page_done", int'(page_done), 0);
        chk(ecc_on == 1'b0, "R1 reset ecc_on", int'(ecc_on), 0);
        chk(length_error == 1'b0, "R1 reset length_error", int'(length_error), 0);

        for (int si = 0; si < 2; si++)
            for (int fi = 0; fi < 2; fi++)
                for (int pi = 0; pi < 2; pi++)
                    for (int ni = 0; ni < 4; ni++)
                        for (int m = 0; m < 4; m++)
                            run_page(si ? 8 : 4, fi ? 2 : 1, pi ? 4 : 3, ns[ni],
                                     m >= 2, m[0], m == 1 || m == 3, 0, 0, 1);

        // R9: short formatted page (only a parity byte missing), then a clean page
        run_page(8, 2, 4, 3, 0, 0, 0, -1, 0, 1);
        run_page(8, 2, 4, 3, 0, 0, 0, 0, 0, 1);
        // R9: long formatted page with relocation, surplus discarded
        run_page(4, 1, 3, 2, 0, 0, 1, 3, 0, 1);
        // R9: short raw page, data tail undefined
        run_page(4, 1, 3, 2, 1, 0, 0, -2, 0, 0);
        // R7: configuration changed after the first byte
        run_page(8, 2, 4, 4, 0, 1, 1, 0, 1, 1);
        run_page(4, 1, 4, 16, 1, 1, 0, 0, 1, 1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule